// File: doc/BRIEF.md
# Pipelined Control Word Generator and Carrier

This block builds the control word for a five-stage in-order pipeline: fetch, decode/register read, execute, memory access, write-back. An opcode is decoded once, in the decode stage, and a new word is produced every clock. The word is split into three groups: execute, memory and write-back. Each group rides the decode/execute, execute/memory and memory/write-back registers in step with its instruction. A group is dropped once its stage has used it. Fetch and decode consume no instruction-specific control.

Each register carries a valid bit, and every stage output is gated by it. A bubble therefore never drives a side effect. Hazard logic sits outside the block and drives it through plain inputs:
- a per-boundary flush, which loads a bubble;
- a decode/execute stall, which either freezes the execute stage or replaces its instruction with a bubble.

Top module: `ctl_pipe_carrier`

## Requirements
- R1: Opcode 6'b000000 (register-register ALU) yields ex_dst_sel=1, ex_alu_op=2'b10, ex_imm_sel=0, no memory control, wb_reg_we=1, wb_load_sel=0.
- R2: Opcode 6'b100011 (load) yields ex_imm_sel=1, ex_alu_op=2'b00, mem_read=1, wb_reg_we=1, wb_load_sel=1, all other fields 0.
- R3: Opcode 6'b101011 (store) yields ex_imm_sel=1, ex_alu_op=2'b00, mem_write=1, all other fields 0.
- R4: Opcode 6'b000100 (branch-if-equal) yields ex_alu_op=2'b01, mem_branch=1, all other fields 0.
- R5: Any other opcode gives an all-zero control word. The instruction's valid bit still travels with it.
- R6: A word accepted at a clock edge appears on the execute outputs after that edge. It appears on the memory outputs one edge later and on the write-back outputs two edges later.
- R7: Each of flush_de, flush_em and flush_mw makes its own register load a bubble: valid 0 and every field 0.
- R8: When stall_de=1, stall_bubble=0 and flush_de=0, the decode/execute register keeps its contents.
- R9: When stall_de=1 and stall_bubble=1, the decode/execute register loads a bubble, and the execute/memory register still takes the previous execute-stage instruction.
- R10: flush_de takes priority over a hold stall: the execute stage becomes a bubble.
- R11: Synchronous active-high rst clears every register, so all outputs read 0 after the edge.
- R12: With id_valid=0, no stage output is ever asserted, whatever the opcode.
- R13: While a hold stall is requested, the execute/memory register receives a bubble, so the frozen instruction is not duplicated downstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_opcode | input | 6 | Opcode in decode |
| stall_de | input | 1 | Stall request at the decode/execute boundary |
| stall_bubble | input | 1 | Stall mode: 0 = hold execute stage, 1 = insert bubble |
| flush_de | input | 1 | Bubble into the decode/execute register |
| flush_em | input | 1 | Bubble into the execute/memory register |
| flush_mw | input | 1 | Bubble into the memory/write-back register |
| ex_valid | output | 1 | Execute stage valid |
| ex_dst_sel | output | 1 | Destination register from the rd field |
| ex_alu_op | output | 2 | ALU mode: 00 add, 01 compare-subtract, 10 by function field |
| ex_imm_sel | output | 1 | Second ALU operand is the immediate |
| mem_valid | output | 1 | Memory stage valid |
| mem_branch | output | 1 | Conditional branch in memory stage |
| mem_read | output | 1 | Data memory read |
| mem_write | output | 1 | Data memory write |
| wb_valid | output | 1 | Write-back stage valid |
| wb_reg_we | output | 1 | Register file write enable |
| wb_load_sel | output | 1 | Write-back data from memory rather than ALU |

## Verification
Two pairs of controls can land in the same cycle.

The first pair is a hold stall and a flush of the decode/execute register. The bench freezes a load in execute and raises flush_de in that same cycle. It expects the execute outputs to read as a bubble and the memory stage to receive a bubble, so that the frozen load disappears rather than reappearing.

The second pair is a bubble-mode stall and normal advancement. The bench checks that the instruction leaving execute still reaches memory with its valid bit set in the cycle the bubble enters execute.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_ALU   = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_CMP  = 2'b01,
        ALU_FUNC = 2'b10
    } alu_mode_e;

    typedef struct packed {
        logic      dst_sel;
        alu_mode_e alu_op;
        logic      imm_sel;
    } ex_ctl_t;

    typedef struct packed {
        logic branch;
        logic rd;
        logic wr;
    } mem_ctl_t;

    typedef struct packed {
        logic reg_we;
        logic load_sel;
    } wb_ctl_t;

    typedef struct packed {
        logic     valid;
        ex_ctl_t  ex;
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } de_word_t;

    typedef struct packed {
        logic     valid;
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } em_word_t;

    typedef struct packed {
        logic    valid;
        wb_ctl_t wb;
    } mw_word_t;

    localparam int DE_W = $bits(de_word_t);
    localparam int EM_W = $bits(em_word_t);
    localparam int MW_W = $bits(mw_word_t);

    function automatic de_word_t decode_opcode(input logic vld, input logic [OPC_W-1:0] opc);
        de_word_t w;
        w = '0;
        w.valid = vld;
        unique case (opc)
            OPC_ALU: begin
                w.ex.dst_sel = 1'b1;
                w.ex.alu_op  = ALU_FUNC;
                w.wb.reg_we  = 1'b1;
            end
            OPC_LOAD: begin
                w.ex.imm_sel  = 1'b1;
                w.mem.rd      = 1'b1;
                w.wb.reg_we   = 1'b1;
                w.wb.load_sel = 1'b1;
            end
            OPC_STORE: begin
                w.ex.imm_sel = 1'b1;
                w.mem.wr     = 1'b1;
            end
            OPC_BEQ: begin
                w.ex.alu_op  = ALU_CMP;
                w.mem.branch = 1'b1;
            end
            default: begin
                w.ex  = '0;
                w.mem = '0;
                w.wb  = '0;
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ctl_decoder.sv
module ctl_decoder
    import ctl_pkg::*;
(
    input  logic             vld,
    input  logic [OPC_W-1:0] opc,
    output de_word_t         word
);

    always_comb begin
        word = decode_opcode(vld, opc);
    end

    always_comb begin
        if (!vld) begin
            assert_idle_word_R12: assert (word.valid == 1'b0);
        end
    end

endmodule

// File: rtl/ctl_stage_reg.sv
module ctl_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic         bubble,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || bubble) begin
            q <= '0;
        end else if (load_en) begin
            q <= d;
        end
    end

    assert_bubble_clears_R7: assert property (@(posedge clk) disable iff (rst)
        bubble |=> (q == '0));

    assert_hold_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !bubble) |=> $stable(q));

    assert_reset_zero_R11: assert property (@(posedge clk)
        rst |=> (q == '0));

endmodule

// File: rtl/ctl_pipe_carrier.sv
module ctl_pipe_carrier
    import ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             id_valid,
    input  logic [OPC_W-1:0] id_opcode,
    input  logic             stall_de,
    input  logic             stall_bubble,
    input  logic             flush_de,
    input  logic             flush_em,
    input  logic             flush_mw,
    output logic             ex_valid,
    output logic             ex_dst_sel,
    output logic [1:0]       ex_alu_op,
    output logic             ex_imm_sel,
    output logic             mem_valid,
    output logic             mem_branch,
    output logic             mem_read,
    output logic             mem_write,
    output logic             wb_valid,
    output logic             wb_reg_we,
    output logic             wb_load_sel
);

    de_word_t id_word;
    de_word_t de_q;
    em_word_t em_d, em_q;
    mw_word_t mw_d, mw_q;

    logic [DE_W-1:0] de_q_raw;
    logic [EM_W-1:0] em_q_raw;
    logic [MW_W-1:0] mw_q_raw;

    logic hold_req, de_load, de_bubble, em_bubble;

    ctl_decoder u_dec (
        .vld  (id_valid),
        .opc  (id_opcode),
        .word (id_word)
    );

    // Boundary control: flush beats every stall; a hold request freezes
    // execute and sends a bubble forward instead of a copy.
    always_comb begin
        hold_req  = stall_de && !stall_bubble;
        de_bubble = flush_de || (stall_de && stall_bubble);
        de_load   = !hold_req;
        em_bubble = flush_em || hold_req;
    end

    // Execute group is dropped here.
    always_comb begin
        em_d.valid = de_q.valid;
        em_d.mem   = de_q.mem;
        em_d.wb    = de_q.wb;
    end

    // Memory group is dropped here.
    always_comb begin
        mw_d.valid = em_q.valid;
        mw_d.wb    = em_q.wb;
    end

    ctl_stage_reg #(.W(DE_W)) u_de (
        .clk     (clk),
        .rst     (rst),
        .load_en (de_load),
        .bubble  (de_bubble),
        .d       (id_word),
        .q       (de_q_raw)
    );

    ctl_stage_reg #(.W(EM_W)) u_em (
        .clk     (clk),
        .rst     (rst),
        .load_en (1'b1),
        .bubble  (em_bubble),
        .d       (em_d),
        .q       (em_q_raw)
    );

    ctl_stage_reg #(.W(MW_W)) u_mw (
        .clk     (clk),
        .rst     (rst),
        .load_en (1'b1),
        .bubble  (flush_mw),
        .d       (mw_d),
        .q       (mw_q_raw)
    );

    always_comb begin
        de_q = de_word_t'(de_q_raw);
        em_q = em_word_t'(em_q_raw);
        mw_q = mw_word_t'(mw_q_raw);
    end

    // Valid-qualified stage outputs.
    always_comb begin
        ex_valid    = de_q.valid;
        ex_dst_sel  = de_q.valid & de_q.ex.dst_sel;
        ex_alu_op   = de_q.valid ? de_q.ex.alu_op : 2'b00;
        ex_imm_sel  = de_q.valid & de_q.ex.imm_sel;
        mem_valid   = em_q.valid;
        mem_branch  = em_q.valid & em_q.mem.branch;
        mem_read    = em_q.valid & em_q.mem.rd;
        mem_write   = em_q.valid & em_q.mem.wr;
        wb_valid    = mw_q.valid;
        wb_reg_we   = mw_q.valid & mw_q.wb.reg_we;
        wb_load_sel = mw_q.valid & mw_q.wb.load_sel;
    end

    assert_ex_to_mem_R6: assert property (@(posedge clk) disable iff (rst)
        (!flush_em && !(stall_de && !stall_bubble)) |=> (mem_valid == $past(ex_valid)));

    assert_mem_to_wb_R6: assert property (@(posedge clk) disable iff (rst)
        !flush_mw |=> (wb_valid == $past(mem_valid)));

    assert_flush_wins_R10: assert property (@(posedge clk) disable iff (rst)
        flush_de |=> !ex_valid);

    assert_hold_bubbles_down_R13: assert property (@(posedge clk) disable iff (rst)
        (stall_de && !stall_bubble) |=> !mem_valid);

    assert_bubble_stall_advances_R9: assert property (@(posedge clk) disable iff (rst)
        (stall_de && stall_bubble && !flush_em) |=> (!ex_valid && mem_valid == $past(ex_valid)));

    assert_store_origin_R3: assert property (@(posedge clk) disable iff (rst)
        mem_write |-> $past(ex_valid && ex_imm_sel));

    assert_idle_decode_R12: assert property (@(posedge clk) disable iff (rst)
        (!id_valid && !stall_de) |=> !ex_valid);

endmodule

// File: tb/test_ctl_pipe_carrier.sv
module test_ctl_pipe_carrier;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       id_valid = 1'b0;
    logic [5:0] id_opcode = 6'b0;
    logic       stall_de = 1'b0;
    logic       stall_bubble = 1'b0;
    logic       flush_de = 1'b0;
    logic       flush_em = 1'b0;
    logic       flush_mw = 1'b0;
    logic       ex_valid, ex_dst_sel, ex_imm_sel;
    logic [1:0] ex_alu_op;
    logic       mem_valid, mem_branch, mem_read, mem_write;
    logic       wb_valid, wb_reg_we, wb_load_sel;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    localparam logic [5:0] OP_R   = 6'b000000;
    localparam logic [5:0] OP_LD  = 6'b100011;
    localparam logic [5:0] OP_ST  = 6'b101011;
    localparam logic [5:0] OP_BEQ = 6'b000100;
    localparam logic [5:0] OP_BAD = 6'b111111;

    always #4 clk = ~clk;

    ctl_pipe_carrier i_ctl_pipe_carrier (
        .clk          (clk),
        .rst          (rst),
        .id_valid     (id_valid),
        .id_opcode    (id_opcode),
        .stall_de     (stall_de),
        .stall_bubble (stall_bubble),
        .flush_de     (flush_de),
        .flush_em     (flush_em),
        .flush_mw     (flush_mw),
        .ex_valid     (ex_valid),
        .ex_dst_sel   (ex_dst_sel),
        .ex_alu_op    (ex_alu_op),
        .ex_imm_sel   (ex_imm_sel),
        .mem_valid    (mem_valid),
        .mem_branch   (mem_branch),
        .mem_read     (mem_read),
        .mem_write    (mem_write),
        .wb_valid     (wb_valid),
        .wb_reg_we    (wb_reg_we),
        .wb_load_sel  (wb_load_sel)
    );

    // Expected vectors: ex {valid,dst,alu[1:0],imm}, mem {valid,br,rd,wr}, wb {valid,we,ld}
    function automatic logic [4:0] exp_ex(input logic [5:0] op);
        case (op)
            OP_R:   return 5'b1_1_10_0;
            OP_LD:  return 5'b1_0_00_1;
            OP_ST:  return 5'b1_0_00_1;
            OP_BEQ: return 5'b1_0_01_0;
            default: return 5'b1_0_00_0;
        endcase
    endfunction

    function automatic logic [3:0] exp_mem(input logic [5:0] op);
        case (op)
            OP_LD:  return 4'b1_010;
            OP_ST:  return 4'b1_001;
            OP_BEQ: return 4'b1_100;
            default: return 4'b1_000;
        endcase
    endfunction

    function automatic logic [2:0] exp_wb(input logic [5:0] op);
        case (op)
            OP_R:   return 3'b1_10;
            OP_LD:  return 3'b1_11;
            default: return 3'b1_00;
        endcase
    endfunction

    function automatic logic [4:0] got_ex();
        return {ex_valid, ex_dst_sel, ex_alu_op, ex_imm_sel};
    endfunction
    function automatic logic [3:0] got_mem();
        return {mem_valid, mem_branch, mem_read, mem_write};
    endfunction
    function automatic logic [2:0] got_wb();
        return {wb_valid, wb_reg_we, wb_load_sel};
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            report();
        end
    end

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        chk("R11 reset ex",  {3'b0, got_ex()},  8'h00);
        chk("R11 reset mem", {4'b0, got_mem()}, 8'h00);
        chk("R11 reset wb",  {5'b0, got_wb()},  8'h00);
        rst = 1'b0;
        tick();
    endtask

    task automatic t_decode(input logic [5:0] op, input string tag);
        id_valid = 1'b1; id_opcode = op;
        tick();
        chk({tag, " R6 ex stage"}, {3'b0, got_ex()}, {3'b0, exp_ex(op)});
        id_valid = 1'b0;
        tick();
        chk({tag, " R6 mem stage"}, {4'b0, got_mem()}, {4'b0, exp_mem(op)});
        chk({tag, " R6 ex empty"}, {3'b0, got_ex()}, 8'h00);
        tick();
        chk({tag, " R6 wb stage"}, {5'b0, got_wb()}, {5'b0, exp_wb(op)});
        tick();
    endtask

    task automatic t_invalid();
        id_valid = 1'b0; id_opcode = OP_LD;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R12 idle outputs", {got_ex(), got_wb()}, 8'h00);
            chk("R12 idle mem", {4'b0, got_mem()}, 8'h00);
        end
    endtask

    task automatic t_flush();
        id_valid = 1'b1; id_opcode = OP_ST; flush_de = 1'b1;
        tick();
        chk("R7 flush_de ex", {3'b0, got_ex()}, 8'h00);
        flush_de = 1'b0;
        tick();
        chk("R7 store loaded", {3'b0, got_ex()}, {3'b0, exp_ex(OP_ST)});
        id_valid = 1'b0; flush_em = 1'b1;
        tick();
        chk("R7 flush_em mem", {4'b0, got_mem()}, 8'h00);
        flush_em = 1'b0;
        id_valid = 1'b1; id_opcode = OP_LD;
        tick();
        id_valid = 1'b0;
        tick();
        chk("R7 load in mem", {4'b0, got_mem()}, {4'b0, exp_mem(OP_LD)});
        flush_mw = 1'b1;
        tick();
        chk("R7 flush_mw wb", {5'b0, got_wb()}, 8'h00);
        flush_mw = 1'b0;
        tick();
    endtask

    task automatic t_hold();
        id_valid = 1'b1; id_opcode = OP_LD;
        tick();
        stall_de = 1'b1; stall_bubble = 1'b0; id_opcode = OP_ST;
        tick();
        chk("R8 ex held", {3'b0, got_ex()}, {3'b0, exp_ex(OP_LD)});
        chk("R13 mem bubble", {4'b0, got_mem()}, 8'h00);
        stall_de = 1'b0;
        tick();
        chk("R8 ex after release", {3'b0, got_ex()}, {3'b0, exp_ex(OP_ST)});
        chk("R8 held load advances", {4'b0, got_mem()}, {4'b0, exp_mem(OP_LD)});
        id_valid = 1'b0;
        tick(); tick(); tick();
    endtask

    task automatic t_bubble_stall();
        id_valid = 1'b1; id_opcode = OP_R;
        tick();
        stall_de = 1'b1; stall_bubble = 1'b1; id_opcode = OP_LD;
        tick();
        chk("R9 ex bubble", {3'b0, got_ex()}, 8'h00);
        chk("R9 mem advanced", {4'b0, got_mem()}, {4'b0, exp_mem(OP_R)});
        stall_de = 1'b0; stall_bubble = 1'b0; id_valid = 1'b0;
        tick();
        chk("R9 wb advanced", {5'b0, got_wb()}, {5'b0, exp_wb(OP_R)});
        tick(); tick();
    endtask

    task automatic t_flush_vs_stall();
        id_valid = 1'b1; id_opcode = OP_LD;
        tick();
        stall_de = 1'b1; stall_bubble = 1'b0; flush_de = 1'b1; id_opcode = OP_ST;
        tick();
        chk("R10 flush beats hold ex", {3'b0, got_ex()}, 8'h00);
        chk("R10 no frozen copy in mem", {4'b0, got_mem()}, 8'h00);
        stall_de = 1'b0; flush_de = 1'b0; id_valid = 1'b0;
        tick();
        chk("R10 load gone from mem", {4'b0, got_mem()}, 8'h00);
        tick(); tick();
    endtask

    task automatic t_reset_midstream();
        id_valid = 1'b1; id_opcode = OP_LD;
        tick();
        id_valid = 1'b0;
        tick();
        rst = 1'b1;
        tick();
        chk("R11 mid reset", {got_ex(), got_wb()}, 8'h00);
        chk("R11 mid reset mem", {4'b0, got_mem()}, 8'h00);
        rst = 1'b0;
        tick();
    endtask

    initial begin
        t_reset();
        t_decode(OP_R,   "R1");
        t_decode(OP_LD,  "R2");
        t_decode(OP_ST,  "R3");
        t_decode(OP_BEQ, "R4");
        t_decode(OP_BAD, "R5");
        t_invalid();
        t_flush();
        t_hold();
        t_bubble_stall();
        t_flush_vs_stall();
        t_reset_midstream();
        done = 1'b1;
        report();
    end

endmodule